// File: doc/BRIEF.md
# Handshake Byte Transfer Engine

This block carries packet bytes between a host processor and a small peripheral controller, one byte per handshake step instead of one bit per shift clock. The host writes an 8-bit port register whose three handshake lines are active low: a transfer-in-progress line, an acknowledge line and a request line. It also writes an 8-bit shift register and a one-bit direction flag. Each time the host changes the in-progress/acknowledge pair while a transfer is open, one byte moves. In host-to-device direction the shift register value is captured. In device-to-host direction the next byte of a loaded response appears in the shift register.

When the host closes a transfer, the captured bytes are offered to a consumer as a packet: a one-cycle strobe, a length and a read port into the capture buffer. A producer loads a response packet by writing a response buffer and pulsing a load strobe with its length. The engine then drives the request line low to show that data is waiting, and high again once the last byte has been taken. Every byte step raises a one-cycle byte interrupt pulse. The pulse comes after a programmable number of clock cycles, or on the next cycle when the port direction register holds all ones.

Top module: `hsx_xfer_engine`

## Requirements
- R1: After reset the port register reads 0x00, the shift register reads 0x00, the packet strobe and the byte interrupt are low, and the port direction register holds 0xFF, which selects immediate interrupts.
- R2: With the direction flag at 1 (host sends) and bit 5 (in-progress) written low, a port write captures the shift register byte only if bits 5:4 differ from their value after the previous evaluation. A write that leaves them unchanged captures nothing and raises no byte interrupt.
- R3: The capture buffer holds DEPTH bytes. A byte step that finds it full drops the byte and raises no byte interrupt.
- R4: When bit 5 goes from low to high, a byte interrupt always follows. If at least one byte was captured, the packet strobe is high for exactly one cycle with the byte count, and the capture count restarts at zero.
- R5: With the direction flag at 0 (device returns) and bit 5 low, a changed bits 5:4 pair loads the next response byte into the shift register and raises a byte interrupt.
- R6: When the byte loaded by R5 is the last byte of the response, bit 3 (request) of the port register is forced to 1.
- R7: When bit 5 is high, was high at the previous evaluation, and bit 4 (acknowledge) changed, bit 3 takes the new bit 4 level and a byte interrupt is raised.
- R8: When bit 5 is high and R7 does not apply, bit 3 is forced to 0 while response bytes remain unsent. Otherwise it keeps the value the host wrote.
- R9: A byte interrupt is a one-cycle pulse. It appears on the cycle after the triggering edge when the direction register is 0xFF, and DELAY_CYC cycles later than that otherwise.
- R10: A response load (length at most DEPTH) restarts the response index at zero, re-evaluates the handshake and raises a byte interrupt.
- R11: A delayed interrupt that expires in the same cycle as a new delayed schedule still pulses, and the new schedule restarts the full delay.
- R12: The capture buffer read port returns the captured bytes in capture order at addresses 0 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_wr | input | 1 | Port register write strobe |
| pb_wdata | input | 8 | Port register write value |
| pb_q | output | 8 | Port register value, including the driven request bit |
| pbdir_wr | input | 1 | Port direction register write strobe |
| pbdir_wdata | input | 8 | Port direction register value |
| aux_wr | input | 1 | Direction flag write strobe |
| aux_dir | input | 1 | Direction flag: 1 host sends, 0 device returns |
| shf_wr | input | 1 | Shift register write strobe |
| shf_wdata | input | 8 | Shift register write value |
| shf_q | output | 8 | Shift register value |
| pkt_valid | output | 1 | One-cycle strobe for a completed captured packet |
| pkt_len | output | 5 | Byte count of the completed packet |
| pkt_raddr | input | 4 | Capture buffer read address |
| pkt_rdata | output | 8 | Capture buffer read data (combinational) |
| rsp_wr | input | 1 | Response buffer write strobe |
| rsp_waddr | input | 4 | Response buffer write address |
| rsp_wdata | input | 8 | Response buffer write data |
| rsp_go | input | 1 | Response load strobe |
| rsp_len | input | 5 | Response length, at most DEPTH |
| byte_irq | output | 1 | Byte interrupt pulse |

## Verification
The delay counter can expire in the same cycle that a new handshake step schedules another delayed interrupt. The bench provokes this by placing an acknowledge toggle, with in-progress held high, exactly DELAY_CYC cycles after an earlier toggle. It expects the pending pulse on that cycle and a second pulse a full DELAY_CYC cycles later. A design that drops either pulse, or one that lets the old count continue instead of restarting it, misses one of the two sampled cycles.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
   // Port register bit positions (all handshake lines active low)
   localparam int PB_REQ = 3;
   localparam int PB_ACK = 4;
   localparam int PB_TIP = 5;
   // Direction register value that selects immediate byte interrupts
   localparam logic [7:0] DIR_ALL_OUT = 8'hFF;

   typedef logic [7:0] byte_t;
endpackage

// File: rtl/hsx_byte_buf.sv
module hsx_byte_buf #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/hsx_irq_delay.sv
module hsx_irq_delay #(
   parameter int DELAY_CYC = 37500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sched,
   input  logic sched_now,
   output logic irq
);
   localparam int CW = $clog2(DELAY_CYC + 1);

   logic fire;

   if (DELAY_CYC < 1) begin : g_bad_delay
      $error("hsx_irq_delay: DELAY_CYC must be at least 1");
   end

   if (DELAY_CYC == 1) begin : g_flag
      logic pend_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= sched && !sched_now;
      end
      assign fire = pend_q;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      // A new delayed schedule restarts the count; an immediate one leaves it alone
      always_ff @(posedge clk) begin
         if (!rst_n)                  cnt_q <= '0;
         else if (sched && !sched_now) cnt_q <= CW'(DELAY_CYC);
         else if (cnt_q != '0)        cnt_q <= cnt_q - CW'(1);
      end
      assign fire = (cnt_q == CW'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= fire || (sched && sched_now);
   end

   AST_IRQ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sched && sched_now) |=> irq); // R9
   AST_IRQ_PULSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(fire || (sched && sched_now))); // R9
endmodule

// File: rtl/hsx_handshake_core.sv
module hsx_handshake_core
   import hsx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH),
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pb_wr,
   input  byte_t         pb_wdata,
   input  logic          pbdir_wr,
   input  byte_t         pbdir_wdata,
   input  logic          aux_wr,
   input  logic          aux_dir,
   input  logic          shf_wr,
   input  byte_t         shf_wdata,
   input  logic          rsp_go,
   input  logic [LW-1:0] rsp_len,
   output logic [AW-1:0] ib_raddr,
   input  byte_t         ib_rdata,
   output logic          ob_we,
   output logic [AW-1:0] ob_waddr,
   output byte_t         ob_wdata,
   output byte_t         pb_q,
   output byte_t         shf_q,
   output logic          pkt_valid,
   output logic [LW-1:0] pkt_len,
   output logic          sched,
   output logic          sched_now
);
   byte_t         b_q, last_b_q, dirb_q, sr_q;
   logic          dir_q;
   logic [LW-1:0] out_q, in_idx_q, in_len_q;

   byte_t         b_eff, dirb_eff, sr_eff, b_nx, sr_nx;
   logic          dir_eff, evaluate, pair_moved, done;
   logic [LW-1:0] in_idx_eff, in_len_eff, in_nx, out_nx;

   always_comb begin
      b_eff      = pb_wr    ? pb_wdata    : b_q;
      dirb_eff   = pbdir_wr ? pbdir_wdata : dirb_q;
      dir_eff    = aux_wr   ? aux_dir     : dir_q;
      sr_eff     = shf_wr   ? shf_wdata   : sr_q;
      in_idx_eff = rsp_go   ? '0          : in_idx_q;
      in_len_eff = rsp_go   ? rsp_len     : in_len_q;
      evaluate   = pb_wr || aux_wr || rsp_go;
      pair_moved = b_eff[PB_TIP:PB_ACK] != last_b_q[PB_TIP:PB_ACK];

      b_nx     = b_eff;
      sr_nx    = sr_eff;
      in_nx    = in_idx_eff;
      out_nx   = out_q;
      ob_we    = 1'b0;
      done     = 1'b0;
      sched    = rsp_go;

      if (evaluate) begin
         if (!b_eff[PB_TIP]) begin
            if (dir_eff) begin
               // host to device: capture while room remains
               if (pair_moved && out_q < LW'(DEPTH)) begin
                  ob_we  = 1'b1;
                  out_nx = out_q + LW'(1);
                  sched  = 1'b1;
               end
            end else if (pair_moved && in_idx_eff < in_len_eff) begin
               // device to host: present next response byte
               sr_nx = ib_rdata;
               in_nx = in_idx_eff + LW'(1);
               if (in_idx_eff + LW'(1) >= in_len_eff) b_nx[PB_REQ] = 1'b1;
               sched = 1'b1;
            end
         end else if (last_b_q[PB_TIP] && (b_eff[PB_ACK] != last_b_q[PB_ACK])) begin
            // idle toggle: request line mirrors acknowledge
            b_nx[PB_REQ] = b_eff[PB_ACK];
            sched        = 1'b1;
         end else begin
            if (!last_b_q[PB_TIP]) begin
               done  = (out_q != '0);
               sched = 1'b1;
            end
            if (in_idx_eff < in_len_eff) b_nx[PB_REQ] = 1'b0;
         end
      end
      if (done) out_nx = '0;

      ob_waddr  = out_q[AW-1:0];
      ob_wdata  = sr_eff;
      ib_raddr  = in_idx_eff[AW-1:0];
      sched_now = (dirb_eff == DIR_ALL_OUT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_q       <= '0;
         last_b_q  <= '0;
         dirb_q    <= DIR_ALL_OUT;
         dir_q     <= 1'b0;
         sr_q      <= '0;
         out_q     <= '0;
         in_idx_q  <= '0;
         in_len_q  <= '0;
         pkt_valid <= 1'b0;
         pkt_len   <= '0;
      end else begin
         b_q       <= b_nx;
         if (evaluate) last_b_q <= b_nx;
         dirb_q    <= dirb_eff;
         dir_q     <= dir_eff;
         sr_q      <= sr_nx;
         out_q     <= out_nx;
         in_idx_q  <= in_nx;
         in_len_q  <= in_len_eff;
         pkt_valid <= done;
         if (done) pkt_len <= out_q;
      end
   end

   assign pb_q  = b_q;
   assign shf_q = sr_q;

   AST_OUT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_q <= LW'(DEPTH)); // R3
   AST_IN_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_idx_q <= in_len_q); // R5
   AST_PKT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> !pkt_valid); // R4
   AST_PKT_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_len != '0) && (out_q == '0)); // R4
   AST_RSP_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_go |-> rsp_len <= LW'(DEPTH)); // R10
   AST_LAST_BYTE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_wr && !pb_wdata[PB_TIP] && !dir_eff && !aux_wr && !rsp_go
       && in_len_q != '0 && in_idx_q == in_len_q - LW'(1) && pair_moved)
      |=> pb_q[PB_REQ]); // R6
endmodule

// File: rtl/hsx_xfer_engine.sv
module hsx_xfer_engine #(
   parameter int DEPTH     = 16,
   parameter int DELAY_CYC = 37500,
   parameter int AW        = $clog2(DEPTH),
   parameter int LW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pb_wr,
   input  logic [7:0]    pb_wdata,
   output logic [7:0]    pb_q,
   input  logic          pbdir_wr,
   input  logic [7:0]    pbdir_wdata,
   input  logic          aux_wr,
   input  logic          aux_dir,
   input  logic          shf_wr,
   input  logic [7:0]    shf_wdata,
   output logic [7:0]    shf_q,
   output logic          pkt_valid,
   output logic [LW-1:0] pkt_len,
   input  logic [AW-1:0] pkt_raddr,
   output logic [7:0]    pkt_rdata,
   input  logic          rsp_wr,
   input  logic [AW-1:0] rsp_waddr,
   input  logic [7:0]    rsp_wdata,
   input  logic          rsp_go,
   input  logic [LW-1:0] rsp_len,
   output logic          byte_irq
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("hsx_xfer_engine: DEPTH must be a power of two of at least 2");
   end

   logic          ob_we, sched, sched_now;
   logic [AW-1:0] ob_waddr, ib_raddr;
   logic [7:0]    ob_wdata, ib_rdata;

   hsx_handshake_core #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_core (
      .clk, .rst_n,
      .pb_wr, .pb_wdata, .pbdir_wr, .pbdir_wdata,
      .aux_wr, .aux_dir, .shf_wr, .shf_wdata,
      .rsp_go, .rsp_len,
      .ib_raddr, .ib_rdata,
      .ob_we, .ob_waddr, .ob_wdata,
      .pb_q, .shf_q, .pkt_valid, .pkt_len,
      .sched, .sched_now
   );

   hsx_byte_buf #(.DEPTH(DEPTH), .AW(AW)) u_capture (
      .clk, .we(ob_we), .waddr(ob_waddr), .wdata(ob_wdata),
      .raddr(pkt_raddr), .rdata(pkt_rdata)
   );

   hsx_byte_buf #(.DEPTH(DEPTH), .AW(AW)) u_response (
      .clk, .we(rsp_wr), .waddr(rsp_waddr), .wdata(rsp_wdata),
      .raddr(ib_raddr), .rdata(ib_rdata)
   );

   hsx_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_irq (
      .clk, .rst_n, .sched, .sched_now, .irq(byte_irq)
   );

   AST_STROBE_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pbdir_wr == 1'b0 && $past(sched_now)) |-> byte_irq); // R4
endmodule

// File: tb/tb_hsx_xfer_engine.sv
`timescale 1ns/10ps
module tb_hsx_xfer_engine;
   localparam int DEPTH = 16;
   localparam int DLY   = 6;
   localparam int AW    = 4;
   localparam int LW    = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pb_wr = 0, pbdir_wr = 0, aux_wr = 0, aux_dir = 0, shf_wr = 0;
   logic rsp_wr = 0, rsp_go = 0;
   logic [7:0] pb_wdata = 0, pbdir_wdata = 0, shf_wdata = 0, rsp_wdata = 0;
   logic [AW-1:0] pkt_raddr = 0, rsp_waddr = 0;
   logic [LW-1:0] rsp_len = 0;
   logic [7:0] pb_q, shf_q, pkt_rdata;
   logic pkt_valid, byte_irq;
   logic [LW-1:0] pkt_len;

   int checks = 0, errors = 0;
   bit finished = 0;
   int exp_len_q[$];
   int exp_byte_q[$];

   always #4 clk = ~clk;

   hsx_xfer_engine #(.DEPTH(DEPTH), .DELAY_CYC(DLY)) dut (
      .clk, .rst_n, .pb_wr, .pb_wdata, .pb_q, .pbdir_wr, .pbdir_wdata,
      .aux_wr, .aux_dir, .shf_wr, .shf_wdata, .shf_q,
      .pkt_valid, .pkt_len, .pkt_raddr, .pkt_rdata,
      .rsp_wr, .rsp_waddr, .rsp_wdata, .rsp_go, .rsp_len, .byte_irq
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // All drivers are called at a falling edge; the next rising edge applies them
   task automatic wr_pb(input logic [7:0] v);
      pb_wr = 1; pb_wdata = v; @(negedge clk); pb_wr = 0;
   endtask
   task automatic wr_dir(input logic [7:0] v);
      pbdir_wr = 1; pbdir_wdata = v; @(negedge clk); pbdir_wr = 0;
   endtask
   task automatic wr_aux(input logic v);
      aux_wr = 1; aux_dir = v; @(negedge clk); aux_wr = 0;
   endtask
   task automatic wr_sr(input logic [7:0] v);
      shf_wr = 1; shf_wdata = v; @(negedge clk); shf_wr = 0;
   endtask
   task automatic wr_rsp(input int a, input logic [7:0] v);
      rsp_wr = 1; rsp_waddr = AW'(a); rsp_wdata = v; @(negedge clk); rsp_wr = 0;
   endtask
   task automatic go_rsp(input int n);
      rsp_go = 1; rsp_len = LW'(n); @(negedge clk); rsp_go = 0;
   endtask
   task automatic expect_pkt(input int n, input int first, input int step);
      exp_len_q.push_back(n);
      for (int i = 0; i < n; i++) exp_byte_q.push_back((first + i * step) & 8'hFF);
   endtask

   // Scoreboard monitor: compares each completed packet (R4, R12)
   always @(negedge clk) begin
      if (rst_n && pkt_valid) begin
         int n;
         bit ok;
         int bad_act, bad_exp;
         ok = 1; bad_act = 0; bad_exp = 0;
         if (exp_len_q.size() == 0) begin
            chk(0, "R4 unexpected packet", int'(pkt_len), 0);
         end else begin
            n = exp_len_q.pop_front();
            if (int'(pkt_len) != n) begin ok = 0; bad_act = pkt_len; bad_exp = n; end
            for (int i = 0; i < n; i++) begin
               int e;
               pkt_raddr = AW'(i);
               #0.1;
               e = exp_byte_q.pop_front();
               if (ok && int'(pkt_rdata) != e) begin ok = 0; bad_act = pkt_rdata; bad_exp = e; end
            end
            chk(ok, "R12 R4 packet length/content", bad_act, bad_exp);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(pb_q == 8'h00, "R1 port reg", pb_q, 8'h00);
      chk(shf_q == 8'h00 && !pkt_valid && !byte_irq, "R1 shift/strobes", shf_q, 0);

      // R2 host sends: direction write alone moves nothing
      wr_aux(1'b1);
      chk(!byte_irq, "R2 no step on direction write", byte_irq, 0);
      wr_pb(8'h30); // close with nothing captured
      chk(byte_irq, "R4 irq on close without data", byte_irq, 1);
      wr_sr(8'hA1); wr_pb(8'h10);
      chk(byte_irq, "R2 capture step irq (R9 immediate)", byte_irq, 1);
      wr_sr(8'hB2); wr_pb(8'h00);
      wr_sr(8'hC3); wr_pb(8'h00);
      chk(!byte_irq, "R2 unchanged pair no irq", byte_irq, 0);
      wr_pb(8'h10);
      expect_pkt(3, 8'hA1, 8'h11);
      wr_pb(8'h30);
      chk(byte_irq, "R4 irq on close with data", byte_irq, 1);

      // R3 overflow: 18 steps, 16 kept
      for (int i = 0; i < 18; i++) begin
         wr_sr(8'(8'h40 + i));
         wr_pb((i % 2 == 0) ? 8'h10 : 8'h00);
         if (i == 16) chk(!byte_irq, "R3 full buffer no irq", byte_irq, 0);
      end
      expect_pkt(16, 8'h40, 1);
      wr_pb(8'h30);
      @(negedge clk);

      // R7 + R9 delayed interrupt
      wr_dir(8'h00);
      wr_pb(8'h28);
      chk(pb_q == 8'h20, "R7 request follows ack low", pb_q, 8'h20);
      chk(!byte_irq, "R9 no immediate pulse", byte_irq, 0);
      repeat (DLY - 1) @(negedge clk);
      chk(!byte_irq, "R9 not before delay", byte_irq, 0);
      @(negedge clk);
      chk(byte_irq, "R9 pulse after delay", byte_irq, 1);
      wr_pb(8'h30);
      chk(pb_q == 8'h38, "R7 request follows ack high", pb_q, 8'h38);
      repeat (DLY + 2) @(negedge clk);

      // R10, R8, R5, R6 response path
      wr_dir(8'hFF);
      wr_rsp(0, 8'h11); wr_rsp(1, 8'h22); wr_rsp(2, 8'h33);
      go_rsp(3);
      chk(pb_q == 8'h30, "R8 request low when data waits", pb_q, 8'h30);
      chk(byte_irq, "R10 irq on load", byte_irq, 1);
      wr_aux(1'b0);
      wr_pb(8'h10);
      chk(shf_q == 8'h11 && byte_irq, "R5 first response byte", shf_q, 8'h11);
      wr_pb(8'h00);
      chk(shf_q == 8'h22, "R5 second response byte", shf_q, 8'h22);
      wr_pb(8'h10);
      chk(shf_q == 8'h33, "R5 third response byte", shf_q, 8'h33);
      chk(pb_q == 8'h18, "R6 request high after last", pb_q, 8'h18);
      wr_pb(8'h30);
      chk(byte_irq && pb_q == 8'h30, "R4 close irq, no packet", pb_q, 8'h30);
      wr_pb(8'h38);
      chk(pb_q == 8'h38, "R8 host value kept when all sent", pb_q, 8'h38);
      wr_rsp(0, 8'h44); wr_rsp(1, 8'h55);
      go_rsp(2);
      chk(pb_q == 8'h30, "R10 reload drives request low", pb_q, 8'h30);
      wr_pb(8'h10);
      chk(shf_q == 8'h44, "R10 index restarted", shf_q, 8'h44);
      wr_pb(8'h30);
      @(negedge clk);

      // R11 expiry coincides with a new delayed schedule
      wr_dir(8'h00);
      wr_pb(8'h20);
      repeat (DLY - 1) @(negedge clk);
      wr_pb(8'h30);
      chk(byte_irq, "R11 expiring pulse kept", byte_irq, 1);
      repeat (DLY - 1) @(negedge clk);
      chk(!byte_irq, "R11 restarted delay not early", byte_irq, 0);
      @(negedge clk);
      chk(byte_irq, "R11 restarted delay pulse", byte_irq, 1);

      repeat (4) @(negedge clk);
      chk(exp_len_q.size() == 0, "R4 all expected packets seen", exp_len_q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule